// File: doc/BRIEF.md
# Page Access-Rights and Fault Priority Checker

This block sits behind a translation lookup. It receives the control fields of the one entry that matched a virtual address, together with the context of the request: current privilege, access kind, whether translation is bypassed, and the protection-id state. From these it derives the read, write and execute rights granted for the page, and a single fault code chosen by a fixed priority.

The rights come from two privilege bounds held in the entry. A 3-bit rights type then selects which of those rights the page may grant. A protection-id match removes write permission. The dirty, break and reference conditions each remove rights from the result, so that a later access to the same page is checked again. A miss input and a load-physical-address flag let the caller obtain the matching miss code from the same output. A parameter selects whether the result is registered or passed straight through.

Top module: `perm_check`

## Requirements
- R1: When `phys_mode` is 1, `rights_o` is 3'b111 and `fault_o` is 0, whatever the other inputs are. Rights bit 0 is read, bit 1 is write and bit 2 is execute.
- R2: When `phys_mode` is 0 and `hit` is 0, `rights_o` is 0. `fault_o` is 3 (non-access data miss) when `lpa_op` is 1. Otherwise it is 1 (instruction miss) for access kind 3 (execute) and 2 (data miss) for any other kind.
- R3: Privilege levels are 2 bits, with 0 the most privileged. Read is allowed when priv <= pl1. Write is allowed when priv <= pl2. Execute is allowed when pl2 <= priv <= pl1.
- R4: Rights type 0 grants read only, 1 grants read and write, 2 grants read and execute, 3 grants all three, and 4 to 7 grant execute only. Each grant is further limited by R3.
- R5: A protection-id match removes write rights. A match needs `pid_en` = 1, a nonzero `ent_aid`, and one of the four `pid_regs` fields equal to {ent_aid, 1'b1}. Field i occupies bits [i*19 +: 19]. On a match, a write access (kind 2) gives fault 4 at once, and no later check runs.
- R6: Access kind 0 (none) skips every check after R5 and gives fault 0. The rights are reported as computed up to that point.
- R7: If the requested right is not granted, `fault_o` is 5 for an execute and 6 for a read or write. No later check runs.
- R8: When `ent_d` is 0, write rights are removed, and a write gives fault 7.
- R9: When `ent_b` is 1, write rights are removed, and a write gives fault 8. This fault overrides R8.
- R10: When `ent_t` is 1, only execute rights remain, and a read or write gives fault 9. This fault overrides R8 and R9.
- R11: With REG_OUT=1 (the default), outputs follow their inputs one clock edge later. While `rst` is high at an edge, both outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| phys_mode | input | 1 | Translation bypassed |
| hit | input | 1 | A valid entry matched the address |
| lpa_op | input | 1 | Request is a load-physical-address operation |
| priv | input | 2 | Current privilege level |
| acc | input | 2 | Access kind: 0 none, 1 read, 2 write, 3 execute |
| pid_en | input | 1 | Protection-id checking enabled |
| pid_regs | input | 76 | Four 19-bit protection-id values |
| ent_pl1 | input | 2 | Entry read/execute privilege bound |
| ent_pl2 | input | 2 | Entry write/execute privilege bound |
| ent_type | input | 3 | Entry rights type |
| ent_aid | input | 18 | Entry access id, 0 means public |
| ent_b | input | 1 | Entry break bit |
| ent_d | input | 1 | Entry dirty bit |
| ent_t | input | 1 | Entry reference-trap bit |
| rights_o | output | 3 | Granted rights {x, w, r} |
| fault_o | output | 4 | Fault code, 0 for none |

## Verification
The logic from inputs to result is combinational. With the default registered stage, both outputs take their value at the first rising edge after the inputs are applied. The bench therefore drives each input set on a falling edge, lets one rising edge pass, and samples at the next falling edge, before it changes anything. The reset result is sampled the same way, one edge after `rst` is raised with nonzero stimulus applied.

// File: rtl/perm_pkg.sv
package perm_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_EXEC  = 2'd3
    } acc_e;

    typedef enum logic [3:0] {
        FLT_NONE     = 4'd0,
        FLT_IMISS    = 4'd1,
        FLT_DMISS    = 4'd2,
        FLT_NA_DMISS = 4'd3,
        FLT_PID      = 4'd4,
        FLT_IPROT    = 4'd5,
        FLT_DRIGHTS  = 4'd6,
        FLT_DIRTY    = 4'd7,
        FLT_BREAK    = 4'd8,
        FLT_PAGEREF  = 4'd9
    } fault_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    typedef struct packed {
        rights_t rights;
        fault_e  fault;
    } result_t;

    localparam rights_t RIGHTS_ALL  = '{x: 1'b1, w: 1'b1, r: 1'b1};
    localparam rights_t RIGHTS_NONE = '{x: 1'b0, w: 1'b0, r: 1'b0};

    // Right needed by a given access kind (none needs nothing)
    function automatic rights_t need_of(acc_e a);
        rights_t n;
        n = RIGHTS_NONE;
        case (a)
            ACC_READ:  n.r = 1'b1;
            ACC_WRITE: n.w = 1'b1;
            ACC_EXEC:  n.x = 1'b1;
            default:   n = RIGHTS_NONE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/perm_rights_decode.sv
module perm_rights_decode
    import perm_pkg::*;
(
    input  logic [1:0] priv,
    input  logic [1:0] pl1,
    input  logic [1:0] pl2,
    input  logic [2:0] rtype,
    output rights_t    rights
);
    logic can_r, can_w, can_x;

    always_comb begin
        can_r = (priv <= pl1);
        can_w = (priv <= pl2);
        can_x = (pl2 <= priv) && (priv <= pl1);
        rights = RIGHTS_NONE;
        case (rtype)
            3'd0: rights.r = can_r;
            3'd1: begin rights.r = can_r; rights.w = can_w; end
            3'd2: begin rights.r = can_r; rights.x = can_x; end
            3'd3: begin rights.r = can_r; rights.w = can_w; rights.x = can_x; end
            default: rights.x = can_x;
        endcase
    end
endmodule

// File: rtl/perm_pid_match.sv
module perm_pid_match #(
    parameter int AID_W   = 18,
    parameter int NUM_PID = 4,
    localparam int PID_W  = AID_W + 1
) (
    input  logic                     pid_en,
    input  logic [AID_W-1:0]         aid,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    output logic                     match
);
    logic [NUM_PID-1:0] eq;
    logic [PID_W-1:0]   key;

    assign key = {aid, 1'b1};

    for (genvar i = 0; i < NUM_PID; i++) begin : g_cmp
        assign eq[i] = (pid_regs[i*PID_W +: PID_W] == key);
    end

    assign match = pid_en && (aid != '0) && (eq != '0);
endmodule

// File: rtl/perm_fault_resolve.sv
module perm_fault_resolve
    import perm_pkg::*;
(
    input  logic    phys_mode,
    input  logic    hit,
    input  logic    lpa_op,
    input  acc_e    acc,
    input  rights_t base,
    input  logic    pid_hit,
    input  logic    ent_b,
    input  logic    ent_d,
    input  logic    ent_t,
    output result_t res
);
    rights_t rts;
    fault_e  flt;

    always_comb begin
        rts = base;
        flt = FLT_NONE;
        if (phys_mode) begin
            rts = RIGHTS_ALL;
        end else if (!hit) begin
            rts = RIGHTS_NONE;
            if (lpa_op)                flt = FLT_NA_DMISS;
            else if (acc == ACC_EXEC)  flt = FLT_IMISS;
            else                       flt = FLT_DMISS;
        end else begin
            if (pid_hit) rts.w = 1'b0;
            if (pid_hit && acc == ACC_WRITE) begin
                flt = FLT_PID;
            end else if (acc == ACC_NONE) begin
                flt = FLT_NONE;
            end else if ((rts & need_of(acc)) == RIGHTS_NONE) begin
                flt = (acc == ACC_EXEC) ? FLT_IPROT : FLT_DRIGHTS;
            end else begin
                // later steps override earlier ones: T outranks B outranks D
                if (!ent_d) begin
                    if (acc == ACC_WRITE) flt = FLT_DIRTY;
                    rts.w = 1'b0;
                end
                if (ent_b) begin
                    if (acc == ACC_WRITE) flt = FLT_BREAK;
                    rts.w = 1'b0;
                end
                if (ent_t) begin
                    if (acc != ACC_EXEC) flt = FLT_PAGEREF;
                    rts.r = 1'b0;
                    rts.w = 1'b0;
                end
            end
        end
        res.rights = rts;
        res.fault  = flt;
    end
endmodule

// File: rtl/perm_check.sv
module perm_check
    import perm_pkg::*;
#(
    parameter int AID_W   = 18,
    parameter int NUM_PID = 4,
    parameter bit REG_OUT = 1'b1,
    localparam int PID_W  = AID_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     phys_mode,
    input  logic                     hit,
    input  logic                     lpa_op,
    input  logic [1:0]               priv,
    input  logic [1:0]               acc,
    input  logic                     pid_en,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    input  logic [1:0]               ent_pl1,
    input  logic [1:0]               ent_pl2,
    input  logic [2:0]               ent_type,
    input  logic [AID_W-1:0]         ent_aid,
    input  logic                     ent_b,
    input  logic                     ent_d,
    input  logic                     ent_t,
    output logic [2:0]               rights_o,
    output logic [3:0]               fault_o
);
    rights_t base;
    logic    pid_hit;
    result_t res;

    perm_rights_decode u_dec (
        .priv   (priv),
        .pl1    (ent_pl1),
        .pl2    (ent_pl2),
        .rtype  (ent_type),
        .rights (base)
    );

    perm_pid_match #(.AID_W(AID_W), .NUM_PID(NUM_PID)) u_pid (
        .pid_en   (pid_en),
        .aid      (ent_aid),
        .pid_regs (pid_regs),
        .match    (pid_hit)
    );

    perm_fault_resolve u_res (
        .phys_mode (phys_mode),
        .hit       (hit),
        .lpa_op    (lpa_op),
        .acc       (acc_e'(acc)),
        .base      (base),
        .pid_hit   (pid_hit),
        .ent_b     (ent_b),
        .ent_d     (ent_d),
        .ent_t     (ent_t),
        .res       (res)
    );

    if (REG_OUT) begin : g_reg
        result_t q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= res;
        end
        assign rights_o = q.rights;
        assign fault_o  = q.fault;

        // R11
        reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (rights_o == $past(res.rights)) && (fault_o == $past(res.fault)));
    end else begin : g_comb
        assign rights_o = res.rights;
        assign fault_o  = res.fault;
    end

    // R1
    phys_full_chk: assert property (@(posedge clk) disable iff (rst)
        phys_mode |-> (res.rights == RIGHTS_ALL) && (res.fault == FLT_NONE));

    // R5
    pid_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (!phys_mode && hit && pid_hit) |-> !res.rights.w);

    // R8
    dirty_strip_chk: assert property (@(posedge clk) disable iff (rst)
        (res.fault == FLT_DIRTY || res.fault == FLT_BREAK) |-> !res.rights.w);

    // R10
    pageref_xonly_chk: assert property (@(posedge clk) disable iff (rst)
        (res.fault == FLT_PAGEREF) |-> (!res.rights.r && !res.rights.w));

    // R2
    miss_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (!phys_mode && !hit) |-> (res.rights == RIGHTS_NONE) && (res.fault != FLT_NONE));
endmodule

// File: tb/perm_check_test.sv
module perm_check_test;
    localparam int CLK_PERIOD = 10;
    localparam int AID_W = 18;
    localparam int PID_W = AID_W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phys_mode = 0, hit = 1, lpa_op = 0, pid_en = 0;
    logic [1:0] priv = 0, acc = 0, ent_pl1 = 0, ent_pl2 = 0;
    logic [4*PID_W-1:0] pid_regs = '0;
    logic [2:0] ent_type = 0;
    logic [AID_W-1:0] ent_aid = 0;
    logic ent_b = 0, ent_d = 1, ent_t = 0;
    logic [2:0] rights_o;
    logic [3:0] fault_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perm_check uut (
        .clk(clk), .rst(rst), .phys_mode(phys_mode), .hit(hit), .lpa_op(lpa_op),
        .priv(priv), .acc(acc), .pid_en(pid_en), .pid_regs(pid_regs),
        .ent_pl1(ent_pl1), .ent_pl2(ent_pl2), .ent_type(ent_type), .ent_aid(ent_aid),
        .ent_b(ent_b), .ent_d(ent_d), .ent_t(ent_t),
        .rights_o(rights_o), .fault_o(fault_o)
    );

    // Expected {rights, fault} from the requirements
    function automatic logic [6:0] model(logic pm, logic h, logic lp, int pv, int ac,
                                         int p1, int p2, int ty, logic pidm,
                                         logic b, logic d, logic t);
        int r, w, x, f;
        bit lr, lw, lx;
        if (pm) return {3'b111, 4'd0};                          // R1
        if (!h) return {3'b000, lp ? 4'd3 : (ac == 3 ? 4'd1 : 4'd2)}; // R2
        lr = pv <= p1; lw = pv <= p2; lx = (pv >= p2) && (pv <= p1); // R3
        r = (ty <= 3) && lr;                                     // R4
        w = (ty == 1 || ty == 3) && lw;
        x = (ty >= 2 && ty != 1) && lx && (ty != 0);
        if (ty == 1) x = 0;
        if (pidm) w = 0;                                         // R5
        f = 0;
        if (pidm && ac == 2) return {x[0], 1'b0, r[0], 4'd4};
        if (ac == 0) return {x[0], w[0], r[0], 4'd0};            // R6
        if ((ac == 1 && r == 0) || (ac == 2 && w == 0) || (ac == 3 && x == 0))
            return {x[0], w[0], r[0], (ac == 3) ? 4'd5 : 4'd6};  // R7
        if (t) begin
            f = (ac != 3) ? 9 : 0;                               // R10
            return {x[0], 2'b00, f[3:0]};
        end
        if (b || !d) begin
            w = 0;
            if (ac == 2) f = b ? 8 : 7;                          // R9, R8
        end
        return {x[0], w[0], r[0], f[3:0]};
    endfunction

    task automatic check(string req, logic [6:0] expv);
        checks++;
        if ({rights_o, fault_o} !== expv) begin
            failures++;
            $display("FAIL %s: rights=%b fault=%0d expected rights=%b fault=%0d",
                     req, rights_o, fault_o, expv[6:4], expv[3:0]);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [AID_W-1:0] aidv;
        // R11: reset clears outputs even with stimulus that would give a fault
        hit = 0; acc = 2;
        @(negedge clk); step();
        check("R11 reset", 7'd0);
        rst = 0;
        step();
        check("R11 first result", {3'b000, 4'd2});

        // R1: physical mode over a spread of inputs
        for (int i = 0; i < 64; i++) begin
            phys_mode = 1; hit = i[0]; acc = i[2:1]; ent_t = i[3]; ent_type = i[5:3];
            step();
            check("R1 phys", {3'b111, 4'd0});
        end
        phys_mode = 0;

        // R2: miss codes
        for (int i = 0; i < 8; i++) begin
            hit = 0; acc = i[1:0]; lpa_op = i[2];
            step();
            check("R2 miss", model(0, 0, lpa_op, 0, acc, 0, 0, 0, 0, 0, 1, 0));
        end
        hit = 1; lpa_op = 0;

        // R3,R4,R6,R7,R8,R9,R10: exhaustive sweep of entry and request
        for (int v = 0; v < 16384; v++) begin
            priv = v[1:0]; acc = v[3:2]; ent_pl1 = v[5:4]; ent_pl2 = v[7:6];
            ent_type = v[10:8]; ent_b = v[11]; ent_d = v[12]; ent_t = v[13];
            step();
            check("R3/R4/R6-R10 sweep",
                  model(0, 1, 0, priv, acc, ent_pl1, ent_pl2, ent_type, 0,
                        ent_b, ent_d, ent_t));
        end

        // R5: protection-id match conditions
        aidv = 18'h2A5A5;
        ent_type = 3; ent_pl1 = 3; ent_pl2 = 3; priv = 0; ent_b = 0; ent_d = 1; ent_t = 0;
        for (int v = 0; v < 96; v++) begin
            int slot;
            logic m;
            pid_en  = v[0];
            ent_aid = v[1] ? aidv : '0;
            acc     = v[3:2];
            slot    = v / 16;           // 0..3 matching slot, 4 none, 5 even key
            pid_regs = {4{19'h00123}};
            if (slot < 4)       pid_regs[slot*PID_W +: PID_W] = {ent_aid, 1'b1};
            else if (slot == 5) pid_regs[2*PID_W +: PID_W]    = {ent_aid, 1'b0};
            m = pid_en && (ent_aid != 0) && (slot < 4);
            step();
            check("R5 pid", model(0, 1, 0, 0, acc, 3, 3, 3, m, 0, 1, 0));
        end

        // R10 over R9 over R8 on a writable page
        pid_en = 0; acc = 2;
        for (int v = 0; v < 8; v++) begin
            ent_b = v[0]; ent_d = v[1]; ent_t = v[2];
            step();
            check("R8/R9/R10 priority", model(0, 1, 0, 0, 2, 3, 3, 3, 0, ent_b, ent_d, ent_t));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule